// File: doc/BRIEF.md
# Fast/normal interrupt entry controller

This block sequences entry into the two interrupt modes of a small 32-bit core. It takes two active-low request pins, which may change at any time relative to the clock, and passes each one through a short synchroniser. When the core signals that an instruction has finished, the block checks the synchronised requests against the two mask flags in the current status word. If a request is allowed, it takes the more urgent one and, in the next cycle, shows the result. The return address and the old status word are held in that mode's banked link and saved-status registers. The status word carries the new mode and mask bits, and a redirect with the vector address goes to the fetch unit.

The block also holds the current status word, which the core can write. In user mode such a write cannot change the two mask flags. An exception-return request, issued while the core is in one of the two interrupt modes, restores the status word from the bank and sends fetch to the banked link value minus 4, both in one step.

Status word layout used throughout: mode field in bits [4:0], fast-interrupt mask F in bit 6, normal-interrupt mask I in bit 7. Mode codes: user 5'b10000, fast 5'b10001, normal 5'b10010, supervisor 5'b10011.

Top module: `intr_entry_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `status` reads 32'h0000_00D3 (supervisor mode, F and I set), `fetch_redirect` and `entry_taken` are 0, and both synchroniser flops hold the inactive high level.
- R2: A request pin is seen through exactly one flop: a low level only counts at a boundary if it was already low at the clock edge before the boundary edge. A pin that falls in the boundary cycle itself does not cause entry there.
- R3: Entry happens only at a clock edge where `insn_done` is high. Requests held low without the strobe leave all outputs unchanged.
- R4: A fast request is ignored while F (bit 6) is set, and a normal request is ignored while I (bit 7) is set.
- R5: When both requests are allowed at the same boundary, the fast one is taken (`entry_cause` = 0).
- R6: Fast entry writes `next_pc`+4 to the fast link register and the whole old status word to the fast saved-status register. It sets the mode to 5'b10001 and sets both F and I, keeps status bits [31:8] and bit 5, and redirects fetch to 32'h1C.
- R7: Normal entry writes `next_pc`+4 to the normal link register and the old status word to the normal saved-status register. It sets the mode to 5'b10010 and sets I, leaves F unchanged, and redirects fetch to 32'h18.
- R8: Entry results appear in the cycle after the boundary edge. `entry_taken` is high for that one cycle only, with `entry_cause` 0 for fast and 1 for normal, and `fetch_redirect` is high with it.
- R9: A status write in user mode updates every bit except bits 7:6, which keep their old value. In any other mode the written word is taken whole.
- R10: In fast or normal mode, `ret_en` loads `status` from that mode's saved-status register and sets `fetch_addr` to its link register minus 4 with `fetch_redirect` high, all in the next cycle. In any other mode `ret_en` has no effect. At one edge, entry takes precedence over return, and return takes precedence over a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fiq_n | input | 1 | Fast interrupt request, active low, asynchronous |
| irq_n | input | 1 | Normal interrupt request, active low, asynchronous |
| insn_done | input | 1 | Instruction-boundary strobe |
| next_pc | input | 32 | Address of the next instruction to execute |
| ret_en | input | 1 | Exception-return request |
| psr_wr_en | input | 1 | Status-word write enable |
| psr_wr_data | input | 32 | Status-word write value |
| status | output | 32 | Current status word |
| fetch_redirect | output | 1 | Fetch-address override valid for one cycle |
| fetch_addr | output | 32 | New fetch address |
| entry_taken | output | 1 | One-cycle pulse on interrupt entry |
| entry_cause | output | 1 | 0 = fast entry, 1 = normal entry |
| lr_fast | output | 32 | Banked fast link register |
| spsr_fast | output | 32 | Banked fast saved-status register |
| lr_norm | output | 32 | Banked normal link register |
| spsr_norm | output | 32 | Banked normal saved-status register |

## Verification
The assertions assume reset is held high for at least one clock edge before the first cycle they look at, and that all inputs except the two request pins are stable around each rising edge. Their `$past` terms rely on this. The request pins need no such assumption for the properties, because the properties only look at the synchronised level. To stay within these limits, the stimulus changes every input, pins included, on the falling edge. It uses the random phase only after reset has been released for several cycles.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;
  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam int FBIT = 6;
  localparam int IBIT = 7;
  localparam int NBANK = 2;
  localparam logic CAUSE_FAST = 1'b0;
  localparam logic CAUSE_NORM = 1'b1;
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter (
  input  logic insn_done,
  input  logic fast_n,
  input  logic norm_n,
  input  logic f_mask,
  input  logic i_mask,
  output logic take,
  output logic cause
);
  import intr_entry_pkg::*;
  logic fast_ok, norm_ok;

  always_comb begin
    fast_ok = insn_done && !fast_n && !f_mask;
    norm_ok = insn_done && !norm_n && !i_mask;
    take    = fast_ok || norm_ok;
    cause   = fast_ok ? CAUSE_FAST : CAUSE_NORM;
  end
endmodule

// File: rtl/intr_psr_bank.sv
module intr_psr_bank #(
  parameter int          XLEN    = 32,
  parameter logic [31:0] FIQ_VEC = 32'h1C,
  parameter logic [31:0] IRQ_VEC = 32'h18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            cause,
  input  logic [XLEN-1:0] next_pc,
  input  logic            ret_en,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] status_q,
  output logic            redirect_q,
  output logic [XLEN-1:0] fetch_q,
  output logic            taken_q,
  output logic            cause_q,
  output logic [XLEN-1:0] lr_out   [intr_entry_pkg::NBANK],
  output logic [XLEN-1:0] spsr_out [intr_entry_pkg::NBANK]
);
  import intr_entry_pkg::*;
  localparam logic [XLEN-1:0] RESET_PSR = XLEN'({2'b11, 1'b0, MODE_SVC});
  localparam logic [XLEN-1:0] STEP      = XLEN'(4);

  logic [XLEN-1:0] lr_bank   [NBANK];
  logic [XLEN-1:0] spsr_bank [NBANK];
  logic [XLEN-1:0] entry_psr, wr_psr;
  logic            in_fast, in_norm, in_user, ret_ok, ret_idx;

  always_comb begin
    in_fast = status_q[4:0] == MODE_FIQ;
    in_norm = status_q[4:0] == MODE_IRQ;
    in_user = status_q[4:0] == MODE_USR;
    ret_ok  = ret_en && (in_fast || in_norm);
    ret_idx = in_norm;
    if (cause == CAUSE_FAST)
      entry_psr = {status_q[XLEN-1:8], 1'b1, 1'b1, status_q[5], MODE_FIQ};
    else
      entry_psr = {status_q[XLEN-1:8], 1'b1, status_q[FBIT], status_q[5], MODE_IRQ};
    if (in_user)
      wr_psr = {wr_data[XLEN-1:8], status_q[IBIT:FBIT], wr_data[5:0]};
    else
      wr_psr = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q   <= RESET_PSR;
      redirect_q <= 1'b0;
      fetch_q    <= '0;
      taken_q    <= 1'b0;
      cause_q    <= CAUSE_FAST;
      for (int b = 0; b < NBANK; b++) begin
        lr_bank[b]   <= '0;
        spsr_bank[b] <= '0;
      end
    end else begin
      redirect_q <= 1'b0;
      taken_q    <= 1'b0;
      if (take) begin
        lr_bank[cause]   <= next_pc + STEP;
        spsr_bank[cause] <= status_q;
        status_q         <= entry_psr;
        fetch_q          <= (cause == CAUSE_NORM) ? XLEN'(IRQ_VEC) : XLEN'(FIQ_VEC);
        redirect_q       <= 1'b1;
        taken_q          <= 1'b1;
        cause_q          <= cause;
      end else if (ret_ok) begin
        status_q   <= spsr_bank[ret_idx];
        fetch_q    <= lr_bank[ret_idx] - STEP;
        redirect_q <= 1'b1;
      end else if (wr_en) begin
        status_q <= wr_psr;
      end
    end
  end

  assign lr_out   = lr_bank;
  assign spsr_out = spsr_bank;

  // R9: user-mode writes never move the mask pair
  p_user_mask_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !take && status_q[4:0] == MODE_USR) |=> $stable(status_q[IBIT:FBIT]));

  // R10: return from fast mode restores status and link-4 together
  p_fast_return_r10: assert property (@(posedge clk) disable iff (rst)
    (ret_en && !take && status_q[4:0] == MODE_FIQ) |=>
      (status_q == $past(spsr_bank[0]) && fetch_q == $past(lr_bank[0]) - STEP && redirect_q));

  // R7: normal entry lands in normal mode with I set
  p_norm_mode_r7: assert property (@(posedge clk) disable iff (rst)
    (taken_q && cause_q == CAUSE_NORM) |-> (status_q[4:0] == MODE_IRQ && status_q[IBIT]));
endmodule

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl #(
  parameter int          XLEN        = 32,
  parameter int          SYNC_STAGES = 1,
  parameter logic [31:0] FIQ_VEC     = 32'h1C,
  parameter logic [31:0] IRQ_VEC     = 32'h18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fiq_n,
  input  logic            irq_n,
  input  logic            insn_done,
  input  logic [XLEN-1:0] next_pc,
  input  logic            ret_en,
  input  logic            psr_wr_en,
  input  logic [XLEN-1:0] psr_wr_data,
  output logic [XLEN-1:0] status,
  output logic            fetch_redirect,
  output logic [XLEN-1:0] fetch_addr,
  output logic            entry_taken,
  output logic            entry_cause,
  output logic [XLEN-1:0] lr_fast,
  output logic [XLEN-1:0] spsr_fast,
  output logic [XLEN-1:0] lr_norm,
  output logic [XLEN-1:0] spsr_norm
);
  import intr_entry_pkg::*;
  localparam int NPIN = 2;

  logic [NPIN-1:0] pin_raw, pin_s;
  logic            take, cause;
  logic [XLEN-1:0] lr_v   [NBANK];
  logic [XLEN-1:0] spsr_v [NBANK];

  assign pin_raw = {irq_n, fiq_n};

  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_sync
      intr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pin_raw[p]), .q(pin_s[p]));
    end
  endgenerate

  intr_arbiter u_arb (
    .insn_done(insn_done), .fast_n(pin_s[0]), .norm_n(pin_s[1]),
    .f_mask(status[FBIT]), .i_mask(status[IBIT]), .take(take), .cause(cause));

  intr_psr_bank #(.XLEN(XLEN), .FIQ_VEC(FIQ_VEC), .IRQ_VEC(IRQ_VEC)) u_bank (
    .clk(clk), .rst(rst), .take(take), .cause(cause), .next_pc(next_pc),
    .ret_en(ret_en), .wr_en(psr_wr_en), .wr_data(psr_wr_data),
    .status_q(status), .redirect_q(fetch_redirect), .fetch_q(fetch_addr),
    .taken_q(entry_taken), .cause_q(entry_cause), .lr_out(lr_v), .spsr_out(spsr_v));

  assign lr_fast   = lr_v[0];
  assign spsr_fast = spsr_v[0];
  assign lr_norm   = lr_v[1];
  assign spsr_norm = spsr_v[1];

  // R5: an allowed fast request always wins the boundary
  p_fast_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (insn_done && !pin_s[0] && !status[FBIT]) |=> (entry_taken && entry_cause == CAUSE_FAST));

  // R4: a fast entry never follows a cycle with F set
  p_fast_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (entry_taken && entry_cause == CAUSE_FAST) |-> !$past(status[FBIT]));

  // R3: no entry without the boundary strobe
  p_boundary_only_r3: assert property (@(posedge clk) disable iff (rst)
    !insn_done |=> !entry_taken);

  // R8: entry always comes with a fetch redirect
  p_entry_redirect_r8: assert property (@(posedge clk) disable iff (rst)
    entry_taken |-> fetch_redirect);

  // R6: fast entry lands in fast mode with both masks set
  p_fast_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (entry_taken && entry_cause == CAUSE_FAST) |->
      (status[4:0] == MODE_FIQ && status[FBIT] && status[IBIT]));
endmodule

// File: tb/intr_entry_ctrl_bench.sv
`timescale 1ns/1ps
module intr_entry_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fiq_n = 1'b1, irq_n = 1'b1, insn_done = 1'b0, ret_en = 1'b0, psr_wr_en = 1'b0;
  logic [31:0] next_pc = '0, psr_wr_data = '0;
  logic [31:0] status, fetch_addr, lr_fast, spsr_fast, lr_norm, spsr_norm;
  logic        fetch_redirect, entry_taken, entry_cause;

  always #2.5 clk = ~clk;

  intr_entry_ctrl u_intr_entry_ctrl (
    .clk(clk), .rst(rst), .fiq_n(fiq_n), .irq_n(irq_n), .insn_done(insn_done),
    .next_pc(next_pc), .ret_en(ret_en), .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data),
    .status(status), .fetch_redirect(fetch_redirect), .fetch_addr(fetch_addr),
    .entry_taken(entry_taken), .entry_cause(entry_cause), .lr_fast(lr_fast),
    .spsr_fast(spsr_fast), .lr_norm(lr_norm), .spsr_norm(spsr_norm));

  int    compared = 0, mismatched = 0;
  string tag = "R1";
  bit    done = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: status layout mode[4:0], F bit 6, I bit 7
  logic [31:0] m_psr, m_fa, m_lrf, m_spf, m_lri, m_spi;
  logic        m_fs, m_is, m_red, m_tk, m_cs;
  always @(posedge clk) begin
    if (rst) begin
      m_psr = 32'hD3; m_fa = 0; m_lrf = 0; m_spf = 0; m_lri = 0; m_spi = 0;
      m_fs = 1; m_is = 1; m_red = 0; m_tk = 0; m_cs = 0;
    end else begin
      bit tf, ti;
      tf = insn_done && !m_fs && !m_psr[6];
      ti = insn_done && !tf && !m_is && !m_psr[7];
      m_red = 0; m_tk = 0;
      if (tf) begin
        m_lrf = next_pc + 4; m_spf = m_psr;
        m_psr[4:0] = 5'b10001; m_psr[6] = 1; m_psr[7] = 1;
        m_fa = 32'h1C; m_red = 1; m_tk = 1; m_cs = 0;
      end else if (ti) begin
        m_lri = next_pc + 4; m_spi = m_psr;
        m_psr[4:0] = 5'b10010; m_psr[7] = 1;
        m_fa = 32'h18; m_red = 1; m_tk = 1; m_cs = 1;
      end else if (ret_en && m_psr[4:0] == 5'b10001) begin
        m_fa = m_lrf - 4; m_psr = m_spf; m_red = 1;
      end else if (ret_en && m_psr[4:0] == 5'b10010) begin
        m_fa = m_lri - 4; m_psr = m_spi; m_red = 1;
      end else if (psr_wr_en) begin
        if (m_psr[4:0] == 5'b10000) m_psr = {psr_wr_data[31:8], m_psr[7:6], psr_wr_data[5:0]};
        else m_psr = psr_wr_data;
      end
      m_fs = fiq_n; m_is = irq_n;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("status", status, m_psr);
      chk("fetch_redirect", 32'(fetch_redirect), 32'(m_red));
      chk("entry_taken", 32'(entry_taken), 32'(m_tk));
      if (m_tk) chk("entry_cause", 32'(entry_cause), 32'(m_cs));
      if (m_red) chk("fetch_addr", fetch_addr, m_fa);
      chk("lr_fast", lr_fast, m_lrf);
      chk("spsr_fast", spsr_fast, m_spf);
      chk("lr_norm", lr_norm, m_lri);
      chk("spsr_norm", spsr_norm, m_spi);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(logic [31:0] d);
    psr_wr_en = 1; psr_wr_data = d; @(negedge clk); psr_wr_en = 0;
  endtask
  task automatic boundary(logic [31:0] pc);
    insn_done = 1; next_pc = pc; @(negedge clk); insn_done = 0;
  endtask
  task automatic do_ret();
    ret_en = 1; @(negedge clk); ret_en = 0;
  endtask

  initial begin
    step(3);
    tag = "R1"; chk("reset status", status, 32'hD3);
    chk("reset redirect", 32'(fetch_redirect), 0);
    rst = 0;
    step(1); chk("post-reset status", status, 32'hD3);
    chk("post-reset taken", 32'(entry_taken), 0);
    tag = "R9"; wr(32'h53);
    tag = "R4"; fiq_n = 0; step(2); boundary(32'h100);
    chk("F masks fast", 32'(entry_taken), 0); fiq_n = 1;
    tag = "R7"; irq_n = 0; step(2); boundary(32'h200);
    chk("norm taken", 32'(entry_taken), 1); chk("norm status", status, 32'hD2);
    chk("norm lr", lr_norm, 32'h204); chk("norm vec", fetch_addr, 32'h18);
    irq_n = 1;
    tag = "R10"; do_ret(); chk("ret status", status, 32'h53); chk("ret addr", fetch_addr, 32'h200);
    tag = "R9"; wr(32'h13);
    tag = "R3"; fiq_n = 0; step(5); chk("no strobe", 32'(fetch_redirect), 0);
    tag = "R6"; boundary(32'h1000);
    chk("fast status", status, 32'hD1); chk("fast lr", lr_fast, 32'h1004);
    chk("fast spsr", spsr_fast, 32'h13); chk("fast vec", fetch_addr, 32'h1C);
    tag = "R8"; step(1); chk("pulse ends", 32'(entry_taken), 0);
    tag = "R4"; irq_n = 0; step(1); boundary(32'h1100); chk("I masks norm", 32'(entry_taken), 0);
    tag = "R10"; do_ret(); chk("ret fast", fetch_addr, 32'h1000); chk("ret fast status", status, 32'h13);
    tag = "R5"; boundary(32'h2000); chk("fast wins", 32'(entry_cause), 0);
    do_ret(); fiq_n = 1; irq_n = 1; step(2);
    tag = "R2"; fiq_n = 0; boundary(32'h3000); chk("late pin", 32'(entry_taken), 0);
    boundary(32'h3004); chk("pin after sync", 32'(entry_taken), 1);
    do_ret(); fiq_n = 1; step(1);
    tag = "R9"; wr(32'h10); wr(32'hA00000D0); chk("user write keeps masks", status, 32'hA0000010);
    tag = "R10"; do_ret(); chk("user ret ignored", 32'(fetch_redirect), 0);
    chk("user ret status", status, 32'hA0000010);
    tag = "R7"; irq_n = 0; step(1); boundary(32'h4000); chk("from user", status, 32'hA0000092);
    irq_n = 1; do_ret(); step(2);
    tag = "R5 R6 R7 R10 random";
    for (int i = 0; i < 3000; i++) begin
      fiq_n = ($urandom % 4) != 0; irq_n = ($urandom % 3) != 0;
      insn_done = ($urandom % 3) == 0; next_pc = $urandom & 32'hFFFF_FFFC;
      ret_en = ($urandom % 6) == 0; psr_wr_en = ($urandom % 10) == 0;
      psr_wr_data = {$urandom, 8'h00} | 32'($urandom % 256) | 32'h10;
      @(negedge clk);
    end
    insn_done = 0; ret_en = 0; psr_wr_en = 0;
    step(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; mismatched++; compared++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule